// File: doc/BRIEF.md
# Shift Rotate Unit with Carry

This block shifts or rotates an 8-, 16- or 32-bit operand by a count that is taken modulo 32. It returns the result and an updated carry flag. An opcode selects the operation. The left shift and the arithmetic left shift are one and the same opcode.

Three rotates move bits around the operand and lose none:
- Plain rotates copy the bit that wraps around into the carry.
- Carry rotates treat the incoming carry as one more bit in the ring.

Two double-precision shifts move a destination operand and fill the opened positions from a second source operand. The source is only read.

Requests enter through a valid/ready port and leave one cycle later through a registered valid/ready port:
- The input is ready whenever the output register is empty or is being drained in the same cycle.
- While the output is valid and not taken, the output holds steady and no new request is accepted.

Operand combinations whose result is not defined are not modelled. They raise a flag that travels with the result.

Top module: `shift_rotate_unit`

## Requirements
- R1: Opcode 0 (left shift, also used for arithmetic left) shifts the operand left by the count and fills the low bits with zeros. The carry becomes the last bit shifted out, which is operand bit (width - count). That bit is 0 when the count exceeds the width.
- R2: Opcode 1 (logical right shift) fills the high bits with zeros. The carry becomes operand bit (count - 1), or 0 when the count exceeds the width.
- R3: Opcode 2 (arithmetic right shift) fills the high bits with the original sign bit. The carry becomes operand bit (count - 1), or the sign bit when the count exceeds the width. For example, 8-bit B0h by 1 gives D8h.
- R4: Opcode 3 rotates left and opcode 4 rotates right, both by (count mod width). For a non-zero masked count, the carry equals result bit 0 after a left rotate and the result's top bit after a right rotate.
- R5: Opcode 5 rotates left and opcode 6 rotates right through the carry, by (count mod (width+1)). The carry acts as the bit above the top bit. Examples at 8 bits:
  - Left, carry 0 with 88h, gives carry 1 with 10h.
  - Left again gives carry 0 with 21h.
  - Right, carry 1 with 10h, gives carry 0 with 88h.
- R6: Opcode 7 shifts the destination left and fills the low count bits with the top count bits of the source. Opcode 8 shifts it right and fills the high count bits with the low count bits of the source. The carry is the last destination bit shifted out. Examples at 16 bits:
  - 9FA6h with source 7C36h, left by 4, gives FA67h.
  - FA67h with source 7C36h, right by 8, gives 36FAh.
- R7: Only the low 5 bits of the 8-bit count are used. A masked count of zero returns the width-masked destination unchanged and passes the carry input through to the carry output.
- R8: The undefined flag is set, and the result is not specified, in any of these cases:
  - a double-precision opcode at 8-bit width;
  - a double-precision opcode at 16-bit width with a masked count above 16;
  - width code 3, which then operates at 32 bits.

  An opcode 9 to 15 also sets the flag and returns the masked destination with the carry passed through.
- R9: Width code 0 selects 8 bits, 1 selects 16 bits and 2 selects 32 bits. Destination and source bits above the selected width are ignored. Result bits above the width are zero.
- R10: The output register loads on in_valid && in_ready, and the result is valid in the next cycle. in_ready is high when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_op | input | 4 | Operation code (0 to 8 defined) |
| in_width | input | 2 | Operand width code |
| in_count | input | 8 | Shift or rotate count; low 5 bits used |
| in_dst | input | 32 | Operand to be shifted |
| in_src | input | 32 | Fill source for double-precision shifts |
| in_carry | input | 1 | Carry flag input |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Result, zero above the width |
| out_carry | output | 1 | Updated carry flag |
| out_undef | output | 1 | Result is undefined for this request |

## Verification
Directed vectors use known worked values and each tells apart a specific fill rule:
- Sign fill against zero fill.
- Carry entering at the bottom against carry entering at the top.
- Fill from the source's high bits against fill from its low bits.

Boundary counts separate the different modulo rules from a plain mask:
- a count equal to the width;
- counts of 9 and 17 for the carry rotates;
- counts past the width;
- a count of 32, which masks to zero.

Random requests over all opcodes, widths and full 8-bit counts, with junk above the selected width, are compared against a bit-at-a-time model. A stalled consumer shows whether the output register holds and blocks new input.

// File: rtl/sru_pkg.sv
package sru_pkg;
  typedef enum logic [3:0] {
    OP_SHL = 4'd0,
    OP_SHR = 4'd1,
    OP_SAR = 4'd2,
    OP_ROL = 4'd3,
    OP_ROR = 4'd4,
    OP_RCL = 4'd5,
    OP_RCR = 4'd6,
    OP_DPL = 4'd7,
    OP_DPR = 4'd8
  } sru_op_e;
endpackage

// File: rtl/sru_lane.sv
// One operand width: every operation computed in parallel, opcode selects.
module sru_lane
  import sru_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = 5
) (
  input  logic [3:0]    op,
  input  logic [CW-1:0] cnt,
  input  logic [W-1:0]  d,
  input  logic [W-1:0]  s,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cy
);
  localparam int WR = W + 1;

  int unsigned kr;
  int unsigned kc;
  int unsigned cn;
  logic [W:0]   ring;
  logic [W:0]   sh_l;
  logic [W:0]   sh_r;
  logic [W:0]   sh_a;
  logic [W-1:0] rot_l;
  logic [W-1:0] rot_r;
  logic [W:0]   rc_l;
  logic [W:0]   rc_r;
  logic [W-1:0] dp_l;
  logic [W-1:0] dp_r;

  always_comb begin
    cn    = int'(cnt);
    kr    = cn % W;
    kc    = cn % WR;
    ring  = {cin, d};
    // Extended by one bit so the last bit out lands in a known slot.
    sh_l  = {1'b0, d} << cnt;
    sh_r  = {d, 1'b0} >> cnt;
    sh_a  = $signed({d, 1'b0}) >>> cnt;
    rot_l = (d << kr) | (d >> (W - kr));
    rot_r = (d >> kr) | (d << (W - kr));
    rc_l  = (ring << kc) | (ring >> (WR - kc));
    rc_r  = (ring >> kc) | (ring << (WR - kc));
    dp_l  = (d << cnt) | (s >> (W - cn));
    dp_r  = (d >> cnt) | (s << (W - cn));
  end

  always_comb begin
    res = d;
    cy  = cin;
    if (cnt != '0) begin
      case (op)
        OP_SHL: begin res = sh_l[W-1:0]; cy = sh_l[W];   end
        OP_SHR: begin res = sh_r[W:1];   cy = sh_r[0];   end
        OP_SAR: begin res = sh_a[W:1];   cy = sh_a[0];   end
        OP_ROL: begin res = rot_l;       cy = rot_l[0];  end
        OP_ROR: begin res = rot_r;       cy = rot_r[W-1]; end
        OP_RCL: {cy, res} = rc_l;
        OP_RCR: {cy, res} = rc_r;
        OP_DPL: begin res = dp_l;        cy = sh_l[W];   end
        OP_DPR: begin res = dp_r;        cy = sh_r[0];   end
        default: begin res = d;          cy = cin;       end
      endcase
    end
  end
endmodule

// File: rtl/sru_stage.sv
// Single output register with valid/ready; ready passes through when drained.
module sru_stage #(
  parameter int PW = 34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int BASEW  = 8,
  parameter int NLANES = 3,
  parameter int CNTIN  = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [3:0]                       in_op,
  input  logic [1:0]                       in_width,
  input  logic [CNTIN-1:0]                 in_count,
  input  logic [(BASEW<<(NLANES-1))-1:0]   in_dst,
  input  logic [(BASEW<<(NLANES-1))-1:0]   in_src,
  input  logic                             in_carry,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [(BASEW<<(NLANES-1))-1:0]   out_result,
  output logic                             out_carry,
  output logic                             out_undef
);
  localparam int MAXW = BASEW << (NLANES - 1);
  localparam int CW   = $clog2(MAXW);
  localparam int PW   = MAXW + 2;
  localparam int DPMIN = 2 * BASEW;

  logic [CW-1:0]   cnt_m;
  logic [MAXW-1:0] lane_res [NLANES];
  logic            lane_cy  [NLANES];
  int              sel;
  int              selw;
  logic            is_dp;
  logic            undef;
  logic [PW-1:0]   pay_in;
  logic [PW-1:0]   pay_out;

  assign cnt_m = in_count[CW-1:0];

  for (genvar gi = 0; gi < NLANES; gi++) begin : g_lane
    localparam int LW = BASEW << gi;
    logic [LW-1:0] r;
    logic          c;
    sru_lane #(.W(LW), .CW(CW)) u_lane (
      .op  (in_op),
      .cnt (cnt_m),
      .d   (in_dst[LW-1:0]),
      .s   (in_src[LW-1:0]),
      .cin (in_carry),
      .res (r),
      .cy  (c)
    );
    assign lane_res[gi] = MAXW'(r);
    assign lane_cy[gi]  = c;
  end

  always_comb begin
    sel   = (int'(in_width) >= NLANES) ? NLANES - 1 : int'(in_width);
    selw  = BASEW << sel;
    is_dp = (in_op == OP_DPL) || (in_op == OP_DPR);
    undef = (in_op > OP_DPR) || (int'(in_width) >= NLANES) ||
            (is_dp && ((selw < DPMIN) || (int'(cnt_m) > selw)));
    pay_in = {lane_res[sel], lane_cy[sel], undef};
  end

  sru_stage #(.PW(PW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {out_result, out_carry, out_undef} = pay_out;
endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
  parameter int BASEW  = 8,
  parameter int NLANES = 3,
  parameter int CNTIN  = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic                           in_ready,
  input logic [3:0]                     in_op,
  input logic [1:0]                     in_width,
  input logic [CNTIN-1:0]               in_count,
  input logic [(BASEW<<(NLANES-1))-1:0] in_dst,
  input logic                           in_carry,
  input logic                           out_valid,
  input logic                           out_ready,
  input logic [(BASEW<<(NLANES-1))-1:0] out_result,
  input logic                           out_carry,
  input logic                           out_undef
);
  localparam int MAXW = BASEW << (NLANES - 1);
  localparam int CW   = $clog2(MAXW);

  logic [MAXW-1:0] wmask;
  int              topbit;
  logic            acc;
  logic            cnt_nz;

  always_comb begin
    int lw;
    lw     = (int'(in_width) >= NLANES) ? MAXW : (BASEW << in_width);
    wmask  = (lw >= MAXW) ? '1 : ((MAXW'(1) << lw) - MAXW'(1));
    topbit = lw - 1;
    acc    = in_valid && in_ready;
    cnt_nz = in_count[CW-1:0] != '0;
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
                                $stable(out_carry) && $stable(out_undef));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cnt_nz |=> out_result == $past(in_dst & wmask) && out_carry == $past(in_carry));

  assert_rol_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cnt_nz && in_op == 4'd3 |=> out_carry == out_result[0]);

  assert_ror_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cnt_nz && in_op == 4'd4 |=> out_carry == out_result[$past(topbit)]);

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_result & ~$past(wmask)) == '0);

  assert_dp_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 4'd7 || in_op == 4'd8) && in_width == 2'd0 |=> out_undef);
endmodule

bind shift_rotate_unit sru_checker #(.BASEW(BASEW), .NLANES(NLANES), .CNTIN(CNTIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_width   (in_width),
  .in_count   (in_count),
  .in_dst     (in_dst),
  .in_carry   (in_carry),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_carry  (out_carry),
  .out_undef  (out_undef)
);

// File: tb/tb_shift_rotate_unit.sv
`timescale 1ns/1ps
module tb_shift_rotate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_width = '0;
  logic [7:0]  in_count = '0;
  logic [31:0] in_dst = '0;
  logic [31:0] in_src = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_carry;
  logic        out_undef;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shift_rotate_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_width(in_width), .in_count(in_count),
    .in_dst(in_dst), .in_src(in_src), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_carry(out_carry), .out_undef(out_undef)
  );

  function automatic string tag_of(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      5, 6: return "R5";
      7, 8: return "R6";
      default: return "R8";
    endcase
  endfunction

  // Bit-at-a-time model of the requirements.
  function automatic void model(input int op, input int wsel, input int cnt,
                                input logic [31:0] d0, input logic [31:0] s0,
                                input logic ci, output logic [31:0] r,
                                output logic co, output logic u);
    int w;
    int c;
    int k;
    logic [31:0] mask;
    logic [31:0] d;
    logic [31:0] s;
    logic b;
    logic cr;
    w    = (wsel == 0) ? 8 : (wsel == 1) ? 16 : 32;
    c    = cnt & 31;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    d    = d0 & mask;
    s    = s0 & mask;
    u    = (op > 8) || (wsel == 3) || ((op == 7 || op == 8) && (w == 8 || c > w));
    co   = ci;
    cr   = ci;
    if (c != 0) begin
      case (op)
        0: for (int i = 0; i < c; i++) begin co = d[w-1]; d = (d << 1) & mask; end
        1: for (int i = 0; i < c; i++) begin co = d[0]; d = d >> 1; end
        2: for (int i = 0; i < c; i++) begin
             b = d[w-1]; co = d[0]; d = d >> 1; d[w-1] = b;
           end
        3: begin
             k = c % w;
             for (int i = 0; i < k; i++) begin b = d[w-1]; d = ((d << 1) & mask) | {31'd0, b}; end
             co = d[0];
           end
        4: begin
             k = c % w;
             for (int i = 0; i < k; i++) begin b = d[0]; d = d >> 1; d[w-1] = b; end
             co = d[w-1];
           end
        5: begin
             k = c % (w + 1);
             for (int i = 0; i < k; i++) begin
               b = d[w-1]; d = ((d << 1) & mask) | {31'd0, cr}; cr = b;
             end
             co = cr;
           end
        6: begin
             k = c % (w + 1);
             for (int i = 0; i < k; i++) begin
               b = d[0]; d = d >> 1; d[w-1] = cr; cr = b;
             end
             co = cr;
           end
        7: for (int i = 0; i < c; i++) begin
             co = d[w-1]; d = (d << 1) & mask;
             if (w - 1 - i >= 0) d[0] = s[w-1-i];
           end
        8: for (int i = 0; i < c; i++) begin
             co = d[0]; d = d >> 1;
             if (i < w) d[w-1] = s[i];
           end
        default: ;
      endcase
    end
    r = d;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic go(input int op, input int wsel, input int cnt, input logic [31:0] d,
                    input logic [31:0] s, input logic ci, output logic [31:0] r,
                    output logic co, output logic u);
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1;
    in_op = 4'(op); in_width = 2'(wsel); in_count = 8'(cnt);
    in_dst = d; in_src = s; in_carry = ci;
    @(negedge clk);
    in_valid = 1'b0;
    r = out_result; co = out_carry; u = out_undef;
    chk("R10", "valid after accept", {31'd0, out_valid}, 32'd1);
  endtask

  task automatic directed(input int op, input int wsel, input int cnt, input logic [31:0] d,
                          input logic [31:0] s, input logic ci, input logic [31:0] er,
                          input logic ec, input string tag);
    logic [31:0] r; logic co; logic u;
    go(op, wsel, cnt, d, s, ci, r, co, u);
    chk(tag, "result", r, er);
    chk(tag, "carry", {31'd0, co}, {31'd0, ec});
  endtask

  task automatic against_model(input int op, input int wsel, input int cnt,
                               input logic [31:0] d, input logic [31:0] s, input logic ci);
    logic [31:0] r; logic co; logic u;
    logic [31:0] er; logic ec; logic eu;
    model(op, wsel, cnt, d, s, ci, er, ec, eu);
    go(op, wsel, cnt, d, s, ci, r, co, u);
    chk("R8", "undef flag", {31'd0, u}, {31'd0, eu});
    if (!(eu && (op == 7 || op == 8))) begin
      chk(tag_of(op), "result", r, er);
      chk(tag_of(op), "carry", {31'd0, co}, {31'd0, ec});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r; logic co; logic u;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R10", "reset in_ready", {31'd0, in_ready}, 32'd1);

    // R1..R3 fill rules and carry
    directed(0, 0, 2, 32'h05, 0, 0, 32'h14, 1'b0, "R1");
    directed(0, 0, 8, 32'h01, 0, 0, 32'h00, 1'b1, "R1");
    directed(1, 0, 1, 32'h50, 0, 0, 32'h28, 1'b0, "R2");
    directed(1, 0, 12, 32'hFF, 0, 1, 32'h00, 1'b0, "R2");
    directed(2, 0, 1, 32'hB0, 0, 0, 32'hD8, 1'b0, "R3");
    directed(2, 0, 20, 32'h80, 0, 0, 32'hFF, 1'b1, "R3");
    directed(2, 1, 4, 32'h7FF3, 0, 0, 32'h07FF, 1'b0, "R3");
    // R4 rotates
    directed(3, 0, 4, 32'h3F, 0, 0, 32'hF3, 1'b1, "R4");
    directed(4, 0, 1, 32'hF0, 0, 1, 32'h78, 1'b0, "R4");
    directed(3, 0, 8, 32'h81, 0, 0, 32'h81, 1'b1, "R4");
    // R5 rotates through carry
    directed(5, 0, 1, 32'h88, 0, 0, 32'h10, 1'b1, "R5");
    directed(5, 0, 1, 32'h10, 0, 1, 32'h21, 1'b0, "R5");
    directed(6, 0, 1, 32'h10, 0, 1, 32'h88, 1'b0, "R5");
    directed(5, 0, 9, 32'h5A, 0, 1, 32'h5A, 1'b1, "R5");
    directed(6, 1, 17, 32'h1234, 0, 0, 32'h1234, 1'b0, "R5");
    // R6 double precision
    directed(7, 1, 4, 32'h9FA6, 32'h7C36, 0, 32'hFA67, 1'b1, "R6");
    directed(8, 1, 8, 32'hFA67, 32'h7C36, 0, 32'h36FA, 1'b0, "R6");
    directed(7, 2, 31, 32'h0000_0003, 32'hFFFF_FFFE, 0, 32'h FFFF_FFFF, 1'b1, "R6");
    // R7 count masking
    directed(0, 2, 32, 32'hDEAD_BEEF, 0, 1, 32'hDEAD_BEEF, 1'b1, "R7");
    directed(5, 0, 64, 32'h0000_00C3, 0, 0, 32'h0000_00C3, 1'b0, "R7");
    // R9 upper operand bits ignored, upper result zero
    directed(0, 0, 1, 32'hABCD_1281, 0, 0, 32'h0000_0002, 1'b1, "R9");
    directed(8, 1, 4, 32'hFFFF_0010, 32'hFFFF_0005, 0, 32'h0000_5001, 1'b0, "R9");
    // R8 undefined cases
    go(7, 1, 20, 32'h1234, 32'h5678, 0, r, co, u);
    chk("R8", "dp16 count>16 flag", {31'd0, u}, 32'd1);
    go(8, 0, 3, 32'h12, 32'h34, 0, r, co, u);
    chk("R8", "dp8 flag", {31'd0, u}, 32'd1);
    go(12, 1, 5, 32'h00FF_4321, 0, 1, r, co, u);
    chk("R8", "reserved op flag", {31'd0, u}, 32'd1);
    chk("R8", "reserved op result", r, 32'h4321);
    chk("R8", "reserved op carry", {31'd0, co}, 32'd1);
    go(0, 2, 3, 32'h1, 0, 0, r, co, u);
    chk("R8", "defined op no flag", {31'd0, u}, 32'd0);

    // R10 back-pressure
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b0;
    in_op = 4'd0; in_width = 2'd0; in_count = 8'd1; in_dst = 32'h81; in_carry = 1'b0;
    @(negedge clk);
    chk("R10", "first result", out_result, 32'h02);
    in_op = 4'd4; in_dst = 32'hF0; in_carry = 1'b1;
    #0.1;
    chk("R10", "in_ready low when stalled", {31'd0, in_ready}, 32'd0);
    repeat (2) begin
      @(negedge clk);
      chk("R10", "held result", out_result, 32'h02);
      chk("R10", "held carry", {31'd0, out_carry}, 32'd1);
    end
    out_ready = 1'b1;
    #0.1;
    chk("R10", "in_ready with drain", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "second result", out_result, 32'h78);
    @(negedge clk);
    chk("R10", "drained", {31'd0, out_valid}, 32'd0);

    // Random sweep over all opcodes, widths and counts
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom % 10);
      if (op == 9) op = 9 + int'($urandom % 7);
      against_model(op, int'($urandom % 4), int'($urandom % 256),
                    $urandom, $urandom, 1'($urandom % 2));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule